// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block chooses the handshake that endpoint 0 of a USB device returns during the stages of a control write transfer. Upstream logic has already decoded each transaction. For every one it presents a single-cycle event that carries the token kind and one flag saying whether the token and its data packet were both good. Software controls the endpoint through four single-cycle strobes: one enables the endpoint FIFO, one sets the halt bit, one clears the halt bit, and one forces a stall. A separate level reports whether the FIFO is empty.

The answer comes out one clock after the transaction. It is a handshake code, or else a request to send a zero-length data packet for the status stage. Three interrupt pulses go to the CPU: a valid SETUP was taken, OUT data was accepted, and the status stage finished. The block also tracks the stage of the transfer. Two stall sources stay in force until the next valid SETUP. The forced-stall command never shows in the halt status bit. The halt bit does show there.

Top module: `ep0_ctrl_handshake`

## Requirements
- R1: A transaction with kind SETUP (txn_kind=0) and txn_ok=1 produces hs_valid=1 with hs_code=ACK (1) and an irq_setup pulse, one cycle later. This holds whatever the stall state is.
- R2: A transaction with txn_ok=0, of any kind, produces no handshake, no zero-length-packet request and no interrupt. It leaves the stage and the FIFO-enable status unchanged.
- R3: In the data stage, an OUT (txn_kind=1) is answered with NAK (2) while the FIFO is not enabled. Once the FIFO is enabled, the OUT is answered with ACK and an irq_rx pulse, and the FIFO-enable status then clears.
- R4: Once STALL (3) has been returned, every later OUT or IN is answered with STALL until a valid SETUP arrives. This holds even if the halt bit is cleared in the meantime.
- R5: A forced-stall strobe makes later OUT and IN transactions get STALL, and halt_status keeps its value. A halt-set strobe also causes STALL and sets halt_status to 1. The halt bit survives a SETUP and is cleared only by the halt-clear strobe.
- R6: An IN (txn_kind=2) in the status stage is answered with NAK unless the FIFO is enabled and fifo_empty=1. In that case zlp_send pulses and hs_valid stays 0.
- R7: A host_ack after a zero-length packet has been sent produces an irq_tx pulse one cycle later and clears the FIFO-enable status. A host_ack with no such packet outstanding is ignored.
- R8: The stage output reads 0 for setup, 1 for data and 2 for status. The stage starts at 0. A valid OUT in the setup stage moves it to 1. A valid IN moves it to 2 from either of the other stages. A valid SETUP always returns it to 0.
- R9: A valid SETUP clears the forced stall, the sticky stall and the FIFO-enable status at the same edge that it is acknowledged.
- R10: STALL outranks NAK, and NAK outranks ACK. An OUT received in the status stage is answered with STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | One-cycle transaction event |
| txn_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN |
| txn_ok | input | 1 | Token and data packet both valid |
| host_ack | input | 1 | Host acknowledged the packet the device sent |
| fifo_empty | input | 1 | Endpoint FIFO holds no data |
| fifo_en_set | input | 1 | CPU strobe: enable the FIFO |
| halt_set | input | 1 | CPU strobe: set the halt bit |
| halt_clr | input | 1 | CPU strobe: clear the halt bit |
| stall_cmd_set | input | 1 | CPU strobe: force a stall without touching the halt bit |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| zlp_send | output | 1 | Send a zero-length data packet |
| irq_setup | output | 1 | Valid SETUP taken |
| irq_rx | output | 1 | OUT data accepted |
| irq_tx | output | 1 | Status stage complete |
| stage | output | 2 | Transfer stage |
| halt_status | output | 1 | Visible halt bit |
| fifo_en_status | output | 1 | FIFO-enable flag |

## Verification
The hardest case to reach is the sticky stall that outlives its own cause. The halt bit is set, a STALL goes out, and then the halt bit is cleared before the next transaction, so any further STALL can come only from the remembered state. The halt scenario creates this by applying halt-set, sending an OUT, and applying halt-clear, with the FIFO enabled so that a missing sticky state would show up as ACK. The forced-stall scenario then checks that halt_status stays unchanged through the same sequence.

// File: rtl/ep0_hs_pkg.sv
// Shared encodings for the endpoint 0 handshake responder.
// Assumes every enum fits the 2-bit fields used at the top-level ports.
package ep0_hs_pkg;
    localparam int KIND_W  = 2;
    localparam int CODE_W  = 2;
    localparam int STAGE_W = 2;

    typedef enum logic [KIND_W-1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2
    } tok_kind_e;

    typedef enum logic [CODE_W-1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    typedef enum logic [STAGE_W-1:0] {
        STG_SETUP  = 2'd0,
        STG_DATA   = 2'd1,
        STG_STATUS = 2'd2
    } stage_e;
endpackage

// File: rtl/ep0_stage_tracker.sv
// Tracks the stage of a control write transfer from the valid token events.
// Assumes at most one of the token strobes is high in any cycle.
module ep0_stage_tracker
    import ep0_hs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   setup_ok,
    input  logic   out_ok,
    input  logic   in_ok,
    output stage_e stage
);
    stage_e stage_q;

    // Advance the stage; a valid SETUP always returns it to the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= STG_SETUP;
        end else if (setup_ok) begin
            stage_q <= STG_SETUP;
        end else if (in_ok) begin
            stage_q <= STG_STATUS;
        end else if (out_ok && stage_q == STG_SETUP) begin
            stage_q <= STG_DATA;
        end
    end

    assign stage = stage_q;
endmodule

// File: rtl/ep0_stall_ctrl.sv
// Holds the three stall sources: forced-stall command, halt bit, and the
// sticky state remembered after a STALL was returned.
// Assumes stall_sent is high only in the cycle a STALL decision is made.
module ep0_stall_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_ok,
    input  logic stall_cmd_set,
    input  logic halt_set,
    input  logic halt_clr,
    input  logic stall_sent,
    output logic stall_active,
    output logic halt_bit
);
    logic cmd_q;
    logic halt_q;
    logic sticky_q;

    // Forced stall: set by the CPU, dropped by a valid SETUP (SETUP wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 1'b0;
        end else if (setup_ok) begin
            cmd_q <= 1'b0;
        end else if (stall_cmd_set) begin
            cmd_q <= 1'b1;
        end
    end

    // Halt bit: only the CPU strobes change it, and set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (halt_set) begin
            halt_q <= 1'b1;
        end else if (halt_clr) begin
            halt_q <= 1'b0;
        end
    end

    // Sticky stall: remembers a returned STALL until the next valid SETUP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (setup_ok) begin
            sticky_q <= 1'b0;
        end else if (stall_sent) begin
            sticky_q <= 1'b1;
        end
    end

    assign stall_active = cmd_q | halt_q | sticky_q;
    assign halt_bit     = halt_q;
endmodule

// File: rtl/ep0_resp_decide.sv
// Chooses the handshake for each valid transaction, registers it, and
// keeps the FIFO-enable flag and the outstanding zero-length-packet state.
// Assumes stall_active and stage come from registers (no combinational loop).
module ep0_resp_decide
    import ep0_hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     setup_ok,
    input  logic     out_ok,
    input  logic     in_ok,
    input  stage_e   stage,
    input  logic     stall_active,
    input  logic     fifo_empty,
    input  logic     fifo_en_set,
    input  logic     host_ack,
    output logic     stall_sent,
    output logic     hs_valid,
    output hs_code_e hs_code,
    output logic     zlp_send,
    output logic     irq_setup,
    output logic     irq_rx,
    output logic     irq_tx,
    output logic     fifo_en
);
    logic     nxt_hs;
    hs_code_e nxt_code;
    logic     nxt_zlp;
    logic     out_accept;
    logic     zlp_done;

    logic     fifo_en_q;
    logic     zlp_pend_q;
    logic     hs_valid_q;
    hs_code_e hs_code_q;
    logic     zlp_q;
    logic     irq_setup_q;
    logic     irq_rx_q;
    logic     irq_tx_q;

    // Response priority: STALL over NAK over ACK; SETUP always acknowledged.
    always_comb begin
        nxt_hs     = 1'b0;
        nxt_code   = HS_NONE;
        nxt_zlp    = 1'b0;
        out_accept = 1'b0;
        if (setup_ok) begin
            nxt_hs   = 1'b1;
            nxt_code = HS_ACK;
        end else if (out_ok) begin
            nxt_hs = 1'b1;
            if (stall_active || stage == STG_STATUS) begin
                nxt_code = HS_STALL;
            end else if (!fifo_en_q) begin
                nxt_code = HS_NAK;
            end else begin
                nxt_code   = HS_ACK;
                out_accept = 1'b1;
            end
        end else if (in_ok) begin
            if (stall_active) begin
                nxt_hs   = 1'b1;
                nxt_code = HS_STALL;
            end else if (!fifo_en_q || !fifo_empty) begin
                nxt_hs   = 1'b1;
                nxt_code = HS_NAK;
            end else begin
                nxt_zlp = 1'b1;
            end
        end
    end

    assign stall_sent = nxt_hs && (nxt_code == HS_STALL);
    assign zlp_done   = host_ack && zlp_pend_q && !setup_ok;

    // FIFO enable: set by the CPU, consumed by SETUP, accepted OUT or status end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b0;
        end else if (setup_ok || out_accept || zlp_done) begin
            fifo_en_q <= 1'b0;
        end else if (fifo_en_set) begin
            fifo_en_q <= 1'b1;
        end
    end

    // Outstanding zero-length packet awaiting the host acknowledgement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zlp_pend_q <= 1'b0;
        end else if (setup_ok || zlp_done) begin
            zlp_pend_q <= 1'b0;
        end else if (nxt_zlp) begin
            zlp_pend_q <= 1'b1;
        end
    end

    // Register the response and the interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid_q  <= 1'b0;
            hs_code_q   <= HS_NONE;
            zlp_q       <= 1'b0;
            irq_setup_q <= 1'b0;
            irq_rx_q    <= 1'b0;
            irq_tx_q    <= 1'b0;
        end else begin
            hs_valid_q  <= nxt_hs;
            hs_code_q   <= nxt_code;
            zlp_q       <= nxt_zlp;
            irq_setup_q <= setup_ok;
            irq_rx_q    <= out_accept;
            irq_tx_q    <= zlp_done;
        end
    end

    assign hs_valid  = hs_valid_q;
    assign hs_code   = hs_code_q;
    assign zlp_send  = zlp_q;
    assign irq_setup = irq_setup_q;
    assign irq_rx    = irq_rx_q;
    assign irq_tx    = irq_tx_q;
    assign fifo_en   = fifo_en_q;
endmodule

// File: rtl/ep0_ctrl_handshake.sv
// Top of the endpoint 0 handshake responder for control write transfers.
// Decodes the transaction event into valid-token strobes and wires the
// stage tracker, stall sources and response decision together.
// Assumes transaction events arrive no more often than every other cycle.
module ep0_ctrl_handshake
    import ep0_hs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_valid,
    input  logic [KIND_W-1:0]  txn_kind,
    input  logic               txn_ok,
    input  logic               host_ack,
    input  logic               fifo_empty,
    input  logic               fifo_en_set,
    input  logic               halt_set,
    input  logic               halt_clr,
    input  logic               stall_cmd_set,
    output logic               hs_valid,
    output logic [CODE_W-1:0]  hs_code,
    output logic               zlp_send,
    output logic               irq_setup,
    output logic               irq_rx,
    output logic               irq_tx,
    output logic [STAGE_W-1:0] stage,
    output logic               halt_status,
    output logic               fifo_en_status
);
    logic     good;
    logic     setup_ok;
    logic     out_ok;
    logic     in_ok;
    logic     stall_active;
    logic     stall_sent;
    stage_e   stage_w;
    hs_code_e code_w;

    // Only transactions with a valid token and packet count at all.
    assign good     = txn_valid && txn_ok;
    assign setup_ok = good && (txn_kind == TK_SETUP);
    assign out_ok   = good && (txn_kind == TK_OUT);
    assign in_ok    = good && (txn_kind == TK_IN);

    ep0_stage_tracker u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .setup_ok (setup_ok),
        .out_ok   (out_ok),
        .in_ok    (in_ok),
        .stage    (stage_w)
    );

    ep0_stall_ctrl u_stall (
        .clk           (clk),
        .rst_n         (rst_n),
        .setup_ok      (setup_ok),
        .stall_cmd_set (stall_cmd_set),
        .halt_set      (halt_set),
        .halt_clr      (halt_clr),
        .stall_sent    (stall_sent),
        .stall_active  (stall_active),
        .halt_bit      (halt_status)
    );

    ep0_resp_decide u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_ok     (setup_ok),
        .out_ok       (out_ok),
        .in_ok        (in_ok),
        .stage        (stage_w),
        .stall_active (stall_active),
        .fifo_empty   (fifo_empty),
        .fifo_en_set  (fifo_en_set),
        .host_ack     (host_ack),
        .stall_sent   (stall_sent),
        .hs_valid     (hs_valid),
        .hs_code      (code_w),
        .zlp_send     (zlp_send),
        .irq_setup    (irq_setup),
        .irq_rx       (irq_rx),
        .irq_tx       (irq_tx),
        .fifo_en      (fifo_en_status)
    );

    assign hs_code = code_w;
    assign stage   = stage_w;
endmodule

// File: rtl/ep0_hs_checker.sv
// Protocol checks for the endpoint 0 handshake responder, bound to the top.
// Keeps its own record of a returned STALL to check persistence.
module ep0_hs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       txn_valid,
    input logic [1:0] txn_kind,
    input logic       txn_ok,
    input logic       host_ack,
    input logic       stall_cmd_set,
    input logic       halt_set,
    input logic       halt_clr,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       zlp_send,
    input logic       irq_setup,
    input logic       irq_rx,
    input logic       irq_tx,
    input logic       halt_status
);
    logic stalled_q;

    // Remember a STALL on the wire until a valid SETUP is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stalled_q <= 1'b0;
        end else if (txn_valid && txn_ok && txn_kind == 2'd0) begin
            stalled_q <= 1'b0;
        end else if (hs_valid && hs_code == 2'd3) begin
            stalled_q <= 1'b1;
        end
    end

    AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ok && txn_kind == 2'd0) |=> (hs_valid && hs_code == 2'd1 && irq_setup)); // R1

    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ok) |=> (!hs_valid && !zlp_send && !irq_setup && !irq_rx)); // R2

    AST_STALL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled_q && txn_valid && txn_ok && txn_kind != 2'd0) |=> (hs_valid && hs_code == 2'd3)); // R4

    AST_FORCED_KEEPS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cmd_set && !halt_set && !halt_clr) |=> (halt_status == $past(halt_status))); // R5

    AST_ZLP_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_valid, zlp_send})); // R6

    AST_TX_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> $past(host_ack)); // R7
endmodule

bind ep0_ctrl_handshake ep0_hs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .txn_valid     (txn_valid),
    .txn_kind      (txn_kind),
    .txn_ok        (txn_ok),
    .host_ack      (host_ack),
    .stall_cmd_set (stall_cmd_set),
    .halt_set      (halt_set),
    .halt_clr      (halt_clr),
    .hs_valid      (hs_valid),
    .hs_code       (hs_code),
    .zlp_send      (zlp_send),
    .irq_setup     (irq_setup),
    .irq_rx        (irq_rx),
    .irq_tx        (irq_tx),
    .halt_status   (halt_status)
);

// File: tb/ep0_ctrl_handshake_test.sv
// Directed bench for the endpoint 0 handshake responder.
module ep0_ctrl_handshake_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_valid = 1'b0;
    logic [1:0] txn_kind = 2'd0;
    logic       txn_ok = 1'b0;
    logic       host_ack = 1'b0;
    logic       fifo_empty = 1'b1;
    logic       fifo_en_set = 1'b0;
    logic       halt_set = 1'b0;
    logic       halt_clr = 1'b0;
    logic       stall_cmd_set = 1'b0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       zlp_send;
    logic       irq_setup;
    logic       irq_rx;
    logic       irq_tx;
    logic [1:0] stage;
    logic       halt_status;
    logic       fifo_en_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] K_SETUP = 2'd0, K_OUT = 2'd1, K_IN = 2'd2;
    localparam logic [1:0] C_NONE = 2'd0, C_ACK = 2'd1, C_NAK = 2'd2, C_STALL = 2'd3;

    always #10 clk = ~clk;

    ep0_ctrl_handshake uut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_ok(txn_ok), .host_ack(host_ack), .fifo_empty(fifo_empty),
        .fifo_en_set(fifo_en_set), .halt_set(halt_set), .halt_clr(halt_clr),
        .stall_cmd_set(stall_cmd_set), .hs_valid(hs_valid), .hs_code(hs_code),
        .zlp_send(zlp_send), .irq_setup(irq_setup), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .stage(stage), .halt_status(halt_status),
        .fifo_en_status(fifo_en_status)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one transaction for a cycle; outputs are sampled at the next negedge.
    task automatic txn(input logic [1:0] kind, input logic ok);
        @(negedge clk);
        txn_valid = 1'b1; txn_kind = kind; txn_ok = ok;
        @(negedge clk);
        txn_valid = 1'b0; txn_ok = 1'b0;
    endtask

    // Pulse a CPU or host strobe for one cycle: 0 fifo_en,1 halt_set,2 halt_clr,3 stall,4 host_ack.
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: fifo_en_set = 1'b1;
            1: halt_set = 1'b1;
            2: halt_clr = 1'b1;
            3: stall_cmd_set = 1'b1;
            default: host_ack = 1'b1;
        endcase
        @(negedge clk);
        fifo_en_set = 1'b0; halt_set = 1'b0; halt_clr = 1'b0;
        stall_cmd_set = 1'b0; host_ack = 1'b0;
    endtask

    task automatic expect_hs(input string req, input logic v, input logic [1:0] code);
        check(req, "hs_valid", int'(hs_valid), int'(v));
        check(req, "hs_code", int'(hs_code), int'(code));
    endtask

    task automatic t_reset();
        expect_hs("R8", 1'b0, C_NONE);
        check("R8", "stage after reset", int'(stage), 0);
        check("R5", "halt after reset", int'(halt_status), 0);
        check("R3", "fifo_en after reset", int'(fifo_en_status), 0);
    endtask

    task automatic t_setup_and_bad();
        txn(K_SETUP, 1'b1);
        expect_hs("R1", 1'b1, C_ACK);
        check("R1", "irq_setup", int'(irq_setup), 1);
        strobe(0);
        txn(K_SETUP, 1'b0);
        expect_hs("R2", 1'b0, C_NONE);
        check("R2", "irq_setup on bad", int'(irq_setup), 0);
        txn(K_OUT, 1'b0);
        expect_hs("R2", 1'b0, C_NONE);
        check("R2", "irq_rx on bad", int'(irq_rx), 0);
        check("R2", "stage kept", int'(stage), 0);
        check("R2", "fifo_en kept", int'(fifo_en_status), 1);
        txn(K_IN, 1'b0);
        check("R2", "zlp on bad IN", int'(zlp_send), 0);
        check("R2", "stage kept after bad IN", int'(stage), 0);
    endtask

    task automatic t_data_stage();
        txn(K_SETUP, 1'b1);
        check("R9", "fifo_en cleared by SETUP", int'(fifo_en_status), 0);
        txn(K_OUT, 1'b1);
        expect_hs("R3", 1'b1, C_NAK);
        check("R8", "stage data", int'(stage), 1);
        strobe(0);
        check("R3", "fifo_en set", int'(fifo_en_status), 1);
        txn(K_OUT, 1'b1);
        expect_hs("R3", 1'b1, C_ACK);
        check("R3", "irq_rx", int'(irq_rx), 1);
        check("R3", "fifo_en consumed", int'(fifo_en_status), 0);
        check("R8", "stage stays data", int'(stage), 1);
    endtask

    task automatic t_status_stage();
        txn(K_IN, 1'b1);
        expect_hs("R6", 1'b1, C_NAK);
        check("R8", "stage status", int'(stage), 2);
        strobe(0);
        fifo_empty = 1'b0;
        txn(K_IN, 1'b1);
        expect_hs("R6", 1'b1, C_NAK);
        fifo_empty = 1'b1;
        txn(K_IN, 1'b1);
        check("R6", "zlp_send", int'(zlp_send), 1);
        check("R6", "no handshake with zlp", int'(hs_valid), 0);
        check("R7", "no irq_tx before ack", int'(irq_tx), 0);
        strobe(4);
        check("R7", "irq_tx", int'(irq_tx), 1);
        check("R7", "fifo_en cleared", int'(fifo_en_status), 0);
        strobe(4);
        check("R7", "spurious host_ack ignored", int'(irq_tx), 0);
    endtask

    task automatic t_forced_stall();
        txn(K_SETUP, 1'b1);
        strobe(0);
        strobe(3);
        check("R5", "halt unchanged by forced stall", int'(halt_status), 0);
        txn(K_OUT, 1'b1);
        expect_hs("R10", 1'b1, C_STALL);
        txn(K_IN, 1'b1);
        expect_hs("R4", 1'b1, C_STALL);
        check("R6", "no zlp while stalled", int'(zlp_send), 0);
        txn(K_SETUP, 1'b1);
        expect_hs("R1", 1'b1, C_ACK);
        check("R9", "fifo_en cleared by SETUP", int'(fifo_en_status), 0);
        txn(K_OUT, 1'b1);
        expect_hs("R9", 1'b1, C_NAK);
        strobe(0);
        txn(K_OUT, 1'b1);
        expect_hs("R9", 1'b1, C_ACK);
    endtask

    task automatic t_halt();
        txn(K_SETUP, 1'b1);
        strobe(1);
        check("R5", "halt_status set", int'(halt_status), 1);
        strobe(0);
        txn(K_OUT, 1'b1);
        expect_hs("R5", 1'b1, C_STALL);
        strobe(2);
        check("R5", "halt_status cleared", int'(halt_status), 0);
        txn(K_OUT, 1'b1);
        expect_hs("R4", 1'b1, C_STALL);
        check("R4", "no irq_rx while sticky", int'(irq_rx), 0);
        strobe(1);
        txn(K_SETUP, 1'b1);
        expect_hs("R1", 1'b1, C_ACK);
        check("R5", "halt survives SETUP", int'(halt_status), 1);
        txn(K_OUT, 1'b1);
        expect_hs("R5", 1'b1, C_STALL);
        strobe(2);
        txn(K_SETUP, 1'b1);
        txn(K_OUT, 1'b1);
        expect_hs("R4", 1'b1, C_NAK);
    endtask

    task automatic t_out_in_status();
        txn(K_SETUP, 1'b1);
        txn(K_IN, 1'b1);
        check("R8", "SETUP to status on IN", int'(stage), 2);
        expect_hs("R6", 1'b1, C_NAK);
        strobe(0);
        txn(K_OUT, 1'b1);
        expect_hs("R10", 1'b1, C_STALL);
        txn(K_SETUP, 1'b1);
        check("R8", "SETUP returns stage", int'(stage), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup_and_bad();
        t_data_stage();
        t_status_stage();
        t_forced_stall();
        t_halt();
        t_out_in_status();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule